// File: doc/BRIEF.md
# Framed Serial Bit Sampler

This block takes a burst of serial bits framed by an active-high enable line and turns it into a stream of single bits with a valid pulse. No bit clock comes with the data. Both the enable line and the data line are oversampled by the fast system clock. The rising edge of the enable line sets the bit timing. A programmed divisor gives the length of one bit in system clocks.

Once a rising edge of the enable is seen, the block strobes the data line at the middle of each bit period. It reports the first bit of a burst with a start flag. When the enable is found low at a strobe point, the block raises an end flag and goes back to waiting for the next rising edge. Both inputs pass through a two-flop synchroniser, and the strobe timing includes that fixed delay. The divisor is read once, when a burst starts.

Top module: `framed_bit_sampler`

## Requirements
- R1: While reset is low, and on the first clock after it is released, `bit_valid`, `burst_start` and `burst_end` are all 0.
- R2: If `frame_en` is first captured high at clock edge k, with an effective divisor D, bit j of the burst is the value of `frame_data` at edge k + D/2 + j*D. That bit appears on `bit_data` with `bit_valid` high for one cycle, registered at edge k + D/2 + j*D + 2.
- R3: The effective divisor D is `div_cfg` with bit 0 forced to 0. When that result is 0, D is 2 instead.
- R4: D is taken from `div_cfg` at the start of a burst. Changes to `div_cfg` while a burst is running do not move that burst's strobe points.
- R5: If `frame_en` is low at a strobe point, `burst_end` pulses for one cycle in the slot where `bit_valid` would have pulsed. `bit_valid` stays low in that slot, and the block waits for a new rising edge.
- R6: `burst_start` pulses together with `bit_valid` for bit 0 of each burst, and for no other bit.
- R7: While a burst is running, `frame_en` is examined only at strobe points. A dip and re-rise of `frame_en` between strobe points neither ends nor restarts the burst.
- R8: While no burst is running and `frame_en` stays low, activity on `frame_data` produces no `bit_valid`, `burst_start` or `burst_end`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, runs faster than the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| div_cfg | input | DIV_W | Bit period in system clocks; bit 0 is ignored |
| frame_en | input | 1 | Active-high burst framing, asynchronous to clk |
| frame_data | input | 1 | Serial data, asynchronous to clk |
| bit_data | output | 1 | Most recent strobed bit |
| bit_valid | output | 1 | One-cycle pulse when `bit_data` holds a new bit |
| burst_start | output | 1 | Marks the first bit of a burst |
| burst_end | output | 1 | Pulse when the enable is found low at a strobe point |

## Verification
The bench runs bursts of one to four bits for every divisor setting from 0 to 17. The odd settings and the settings 0 and 1 test the rounding to an even divisor, and the even settings test the mid-bit placement. The bit patterns differ from burst to burst, so a strobe that is one cycle early or late picks up a neighbouring bit or the idle level. Further bursts change the divisor during a burst, or pull the enable low for one cycle between strobe points. Each of these fails if the timer reloads or if the burst state reacts to an edge of the enable outside a strobe point. An idle stretch with the data toggling confirms that nothing starts without a rising edge of the enable.

// File: rtl/fbs_pkg.sv
// Shared types for the framed bit sampler.
package fbs_pkg;
    // Burst state: waiting for a rising edge, or strobing a running burst.
    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } fbs_state_e;
endpackage

// File: rtl/fbs_sync.sv
// Two-flop synchroniser for a bundle of asynchronous single-bit inputs.
// Assumes: each bit is independent; the two-cycle latency is accounted for
// by the caller.
module fbs_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Capture the raw inputs, then retime them once more.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign d_sync = sync_q;
endmodule

// File: rtl/fbs_edge.sv
// Rising-edge detector for a signal that is already synchronous to clk.
// Assumes: lvl is the output of a synchroniser.
module fbs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic prev_q;

    // Remember the level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/fbs_timer.sv
// Strobe timer. On start it captures the even bit period from the divisor
// setting and first fires half a period later; after that it fires once
// per period while run is high.
// Assumes: start is only raised while run is low.
module fbs_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [DIV_W-1:0] div_cfg,
    output logic             tick
);
    logic [DIV_W-1:0] half_raw;
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] per_q;
    logic [DIV_W-1:0] cnt_q;

    // Force an even divisor of at least 2: half is at least 1.
    always_comb begin
        half_raw = div_cfg >> 1;
        half     = (half_raw == '0) ? DIV_W'(1) : half_raw;
    end

    // Load the half-period offset at start, then count whole periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= DIV_W'(2);
            cnt_q <= '0;
        end else if (start) begin
            per_q <= half << 1;
            cnt_q <= half - DIV_W'(1);
        end else if (run) begin
            if (cnt_q == '0) cnt_q <= per_q - DIV_W'(1);
            else             cnt_q <= cnt_q - DIV_W'(1);
        end
    end

    assign tick = run && (cnt_q == '0);

    // R3: the count never reaches the latched period.
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < per_q));
    // R4: the latched period holds still while a burst runs.
    a_r4_period_held: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start && $past(run)) |-> $stable(per_q));
endmodule

// File: rtl/framed_bit_sampler.sv
// Framed serial bit sampler. Oversamples an enable-framed serial line with
// the system clock, aligns a mid-bit strobe to the enable rising edge and
// emits one bit per programmed period. The enable is examined only at strobe
// points; low there ends the burst.
// Assumes: the bit rate is an even submultiple of clk, and the data is
// stable around each mid-bit point.
module framed_bit_sampler
    import fbs_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_cfg,
    input  logic             frame_en,
    input  logic             frame_data,
    output logic             bit_data,
    output logic             bit_valid,
    output logic             burst_start,
    output logic             burst_end
);
    logic [1:0]  sync_bus;
    logic        en_s;
    logic        data_s;
    logic        en_rise;
    logic        start;
    logic        tick;
    logic        take;
    logic        first_q;
    fbs_state_e  state_q;

    fbs_sync #(.WIDTH(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({frame_en, frame_data}),
        .d_sync  (sync_bus)
    );
    assign en_s   = sync_bus[1];
    assign data_s = sync_bus[0];

    fbs_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (en_s),
        .rise  (en_rise)
    );

    assign start = en_rise && (state_q == S_IDLE);

    fbs_timer #(.DIV_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .run     (state_q == S_RUN),
        .div_cfg (div_cfg),
        .tick    (tick)
    );

    assign take = tick && en_s;

    // Burst state: begin on a rising edge, end when the enable is low at a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                         state_q <= S_IDLE;
        else if (start)                     state_q <= S_RUN;
        else if (tick && !en_s)             state_q <= S_IDLE;
    end

    // Track whether the next strobed bit is the first one of the burst.
    always_ff @(posedge clk) begin
        if (!rst_n)     first_q <= 1'b0;
        else if (start) first_q <= 1'b1;
        else if (take)  first_q <= 1'b0;
    end

    // Register the strobed bit and the burst flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_data    <= 1'b0;
            bit_valid   <= 1'b0;
            burst_start <= 1'b0;
            burst_end   <= 1'b0;
        end else begin
            if (take) bit_data <= data_s;
            bit_valid   <= take;
            burst_start <= take && first_q;
            burst_end   <= tick && !en_s;
        end
    end

    // R6: a start flag only comes with a valid bit.
    a_r6_start_with_bit: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |-> bit_valid);
    // R5: an end flag leaves the sampler idle and never shares a slot with a bit.
    a_r5_end_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        burst_end |-> (!bit_valid && state_q == S_IDLE));
    // R2: a valid bit is only produced while a burst is running.
    a_r2_bit_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> (state_q == S_RUN));
    // R8: two idle cycles in a row produce no bit.
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && $past(state_q) == S_IDLE) |-> !bit_valid);
endmodule

// File: tb/sim_framed_bit_sampler.sv
module sim_framed_bit_sampler;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [DIV_W-1:0] div_cfg;
    logic             frame_en;
    logic             frame_data;
    logic             bit_data;
    logic             bit_valid;
    logic             burst_start;
    logic             burst_end;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    framed_bit_sampler #(.DIV_W(DIV_W)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .div_cfg     (div_cfg),
        .frame_en    (frame_en),
        .frame_data  (frame_data),
        .bit_data    (bit_data),
        .bit_valid   (bit_valid),
        .burst_start (burst_start),
        .burst_end   (burst_end)
    );

    // Compare all outputs after one edge against expected values.
    task automatic check_out(input string tag, input int e, input logic ev,
                             input logic eb, input logic es, input logic ee);
        logic bad;
        checks++;
        bad = (bit_valid !== ev) || (ev && bit_data !== eb) ||
              (burst_start !== es) || (burst_end !== ee);
        if (bad) begin
            errors++;
            $display("FAIL %s edge %0d: vld/bit/start/end got %b%b%b%b exp %b%b%b%b",
                     tag, e, bit_valid, bit_data, burst_start, burst_end,
                     ev, eb, es, ee);
        end
    endtask

    // Drive one burst and check every edge; cycle c is the edge that first
    // captures the enable high.
    task automatic run_burst(input string tag, input int rdiv, input int nbits,
                             input int pat, input int glitch, input bit chg);
        int d;
        int h;
        int first_e;
        int last_e;
        int total;
        d = rdiv & 254;
        if (d == 0) d = 2;
        h = d / 2;
        first_e = 2 + h;
        last_e  = first_e + nbits * d;
        total   = last_e + 2;
        div_cfg = DIV_W'(rdiv);
        for (int c = 0; c <= total + 1; c++) begin
            @(negedge clk);
            if (c > 0) begin
                int e;
                int j;
                logic ev;
                logic eb;
                e  = c - 1;
                ev = 1'b0;
                eb = 1'b0;
                j  = 0;
                if (e >= first_e && ((e - first_e) % d) == 0) begin
                    j = (e - first_e) / d;
                    if (j < nbits) begin
                        ev = 1'b1;
                        eb = 1'((pat >> j) & 1);
                    end
                end
                // R2 bit timing, R6 start flag, R5 end flag
                check_out(tag, e, ev, eb, ev && (j == 0), e == last_e);
            end
            if (chg && c == 3) div_cfg = DIV_W'(rdiv ^ 6);
            frame_en = (c < nbits * d) && (c != glitch);
            frame_data = frame_en ? 1'((pat >> (c / d)) & 1) : 1'(c & 1);
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            frame_en   = 1'b0;
            frame_data = 1'(i & 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        div_cfg    = '0;
        frame_en   = 1'b0;
        frame_data = 1'b0;
        // R1: outputs idle during reset, with inputs wiggling
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            frame_en   = 1'(i & 1);
            frame_data = 1'(~i & 1);
            check_out("R1", i, 1'b0, 1'b0, 1'b0, 1'b0);
        end
        @(negedge clk);
        frame_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1", -1, 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);

        // R8: idle line with data toggling
        for (int i = 0; i < 24; i++) begin
            frame_data = 1'(i & 1);
            @(negedge clk);
            check_out("R8", i, 1'b0, 1'b0, 1'b0, 1'b0);
        end

        // R2 / R3: sweep of divisor settings and burst lengths
        for (int r = 0; r <= 17; r++) begin
            for (int n = 1; n <= 4; n++) begin
                run_burst(((r & 1) != 0 || r < 2) ? "R3" : "R2",
                          r, n, (r * 7 + n * 5) ^ 10, -1, 1'b0);
            end
        end

        // R7: one-cycle enable dip between strobe points
        for (int r = 4; r <= 12; r += 4)
            run_burst("R7", r, 3, 5 + r, r - 1, 1'b0);

        // R4: divisor changed in the middle of a burst
        for (int r = 6; r <= 14; r += 4)
            run_burst("R4", r, 4, 9 + r, -1, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule